// File: doc/BRIEF.md
# Adaptive Non-Overlap Gate Sequencer

This block turns a raw PWM request into the two gate commands of a synchronous buck power stage. There is no fixed dead-time counter. A switch is commanded on only after a sense flag shows that the opposite gate has fallen below its off threshold. That threshold comparison is done outside the block and arrives as a one-bit flag per gate. Dead time therefore adapts to the real discharge of each gate. The low-side switch stays on for the whole off-time, so the stage can sink current as well as source it. PWM requests held permanently high or permanently low are followed without end.

When the enable input is removed during a high-side pulse, the block does not cut that pulse short. It finishes the pulse and stops when the PWM request falls. When enable is removed at any other moment, both commands drop at once. If a gate never reports off within `WAIT_LIMIT` clock cycles, the block drives both commands low and raises a fault. The fault stays set until enable is removed.

Top module: `gate_nonoverlap_ctrl`

## Requirements
- R1: After reset, `ugate_cmd`, `lgate_cmd` and `fault` are all 0.
- R2: `ugate_cmd` and `lgate_cmd` are never 1 in the same cycle.
- R3: `ugate_cmd` rises only if, at the clock edge that sets it, `lgate_cmd` was 0 and `lower_gate_low` was 1 (a sense flag of 1 means that gate is below its off threshold). With the flag already 1, the high side turns on two cycles after enable rises with `pwm_in` high, one of them with both commands low.
- R4: `lgate_cmd` rises only if, at the clock edge that sets it, `ugate_cmd` was 0 and `upper_gate_low` was 1. While that flag stays 0, `lgate_cmd` stays 0. Once the flag reads 1 at an edge, `lgate_cmd` is 1 after that edge.
- R5: A change of `pwm_in` releases the conducting command one cycle later. `pwm_in` falling clears `ugate_cmd`, and `pwm_in` rising clears `lgate_cmd`.
- R6: If `enable` falls while `ugate_cmd` is 1, the high-side pulse continues for as long as `pwm_in` stays 1. When `pwm_in` falls, both commands go to 0 one cycle later, and the low side is not switched on.
- R7: If `enable` is 0 while the high side is not conducting, both commands are 0 one cycle later. They stay 0 whatever `pwm_in` and the sense flags do.
- R8: A `pwm_in` held at 1 keeps `ugate_cmd` at 1 indefinitely (100 % duty). A `pwm_in` held at 0 keeps `lgate_cmd` at 1 indefinitely (0 % duty, full-time sink).
- R9: If the block waits `WAIT_LIMIT` consecutive cycles for a sense flag that never reads 1, `fault` becomes 1 and both commands are 0. The fault persists while `enable` is 1 and clears one cycle after `enable` goes to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_in | input | 1 | Raw PWM request: 1 asks for the high side, 0 for the low side |
| enable | input | 1 | Run request; removal stops switching in step with the PWM waveform |
| upper_gate_low | input | 1 | 1 when the high-side gate is sensed below its off threshold |
| lower_gate_low | input | 1 | 1 when the low-side gate is sensed below its off threshold |
| ugate_cmd | output | 1 | High-side gate command |
| lgate_cmd | output | 1 | Low-side gate command |
| fault | output | 1 | Sense-confirmation timeout has occurred |

## Verification
The bench builds the block with `WAIT_LIMIT` set to 8 instead of the default 16. This brings the timeout fault within a few cycles of a stuck sense flag and lets the bench check the cycle before and the cycle of the trip. During the random phase, the bench's gate model reports each gate off 1 to 4 cycles after its command falls. That is always below the limit, so the adaptive dead time varies widely and no fault should ever appear. The random phase also drops enable at random points, which exercises both the pulse-completing stop and the immediate stop.

// File: rtl/gno_pkg.sv
package gno_pkg;

    // Phases of the switching cycle. Wait phases hold both commands low
    // until the opposite gate reports off.
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_WAIT_UP = 3'd1,
        PH_UP      = 3'd2,
        PH_WAIT_DN = 3'd3,
        PH_DN      = 3'd4,
        PH_TRIP    = 3'd5
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   up;
        logic   dn;
        logic   trip;
    } seq_regs_t;

    function automatic logic is_wait(input phase_e p);
        return (p == PH_WAIT_UP) || (p == PH_WAIT_DN);
    endfunction

endpackage

// File: rtl/gno_stop_latch.sv
// Remembers a removed enable until the sequencer has reached idle, so a
// brief enable drop during a pulse still ends switching at the pulse end.
module gno_stop_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic idle,
    output logic stop_req
);

    logic pend_d, pend_q;

    always_comb begin
        if (idle) begin
            pend_d = 1'b0;
        end else begin
            pend_d = pend_q | ~enable;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= pend_d;
        end
    end

    assign stop_req = ~enable | pend_q;

endmodule

// File: rtl/gno_wait_timer.sv
// Counts cycles spent in a wait phase; flags when the limit is used up.
module gno_wait_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic waiting,
    output logic expired
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (restart) begin
            cnt_d = '0;
        end else if (waiting && (cnt_q != LAST)) begin
            cnt_d = cnt_q + 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = waiting && (cnt_q == LAST);

endmodule

// File: rtl/gno_phase_fsm.sv
// Switching-cycle sequencer. Commands are registered and derived from the
// next phase, so no path can set both in one cycle.
module gno_phase_fsm
    import gno_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwm,
    input  logic enable,
    input  logic stop_req,
    input  logic upper_low,
    input  logic lower_low,
    input  logic expired,
    output logic wait_restart,
    output logic waiting,
    output logic idle,
    output logic up_cmd,
    output logic dn_cmd,
    output logic trip
);

    seq_regs_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        unique case (cur_q.phase)
            PH_IDLE: begin
                if (enable && !stop_req) begin
                    nxt_d.phase = pwm ? PH_WAIT_UP : PH_WAIT_DN;
                end
            end
            PH_WAIT_UP: begin
                if (stop_req) begin
                    nxt_d.phase = PH_IDLE;
                end else if (!pwm) begin
                    nxt_d.phase = PH_WAIT_DN;
                end else if (lower_low) begin
                    nxt_d.phase = PH_UP;
                end else if (expired) begin
                    nxt_d.phase = PH_TRIP;
                end
            end
            PH_UP: begin
                // A pending stop waits for the pulse to end.
                if (!pwm) begin
                    nxt_d.phase = stop_req ? PH_IDLE : PH_WAIT_DN;
                end
            end
            PH_WAIT_DN: begin
                if (stop_req) begin
                    nxt_d.phase = PH_IDLE;
                end else if (pwm) begin
                    nxt_d.phase = PH_WAIT_UP;
                end else if (upper_low) begin
                    nxt_d.phase = PH_DN;
                end else if (expired) begin
                    nxt_d.phase = PH_TRIP;
                end
            end
            PH_DN: begin
                if (stop_req) begin
                    nxt_d.phase = PH_IDLE;
                end else if (pwm) begin
                    nxt_d.phase = PH_WAIT_UP;
                end
            end
            PH_TRIP: begin
                if (!enable) begin
                    nxt_d.phase = PH_IDLE;
                end
            end
            default: nxt_d.phase = PH_IDLE;
        endcase
        nxt_d.up   = (nxt_d.phase == PH_UP);
        nxt_d.dn   = (nxt_d.phase == PH_DN);
        nxt_d.trip = (nxt_d.phase == PH_TRIP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{phase: PH_IDLE, up: 1'b0, dn: 1'b0, trip: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign wait_restart = is_wait(nxt_d.phase) && (nxt_d.phase != cur_q.phase);
    assign waiting      = is_wait(cur_q.phase);
    assign idle         = (cur_q.phase == PH_IDLE);
    assign up_cmd       = cur_q.up;
    assign dn_cmd       = cur_q.dn;
    assign trip         = cur_q.trip;

endmodule

// File: rtl/gate_nonoverlap_ctrl.sv
module gate_nonoverlap_ctrl #(
    parameter int WAIT_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic enable,
    input  logic upper_gate_low,
    input  logic lower_gate_low,
    output logic ugate_cmd,
    output logic lgate_cmd,
    output logic fault
);

    logic stop_req;
    logic idle;
    logic waiting;
    logic wait_restart;
    logic expired;

    gno_stop_latch u_stop (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .idle     (idle),
        .stop_req (stop_req)
    );

    gno_wait_timer #(
        .LIMIT (WAIT_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wait_restart),
        .waiting (waiting),
        .expired (expired)
    );

    gno_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwm          (pwm_in),
        .enable       (enable),
        .stop_req     (stop_req),
        .upper_low    (upper_gate_low),
        .lower_low    (lower_gate_low),
        .expired      (expired),
        .wait_restart (wait_restart),
        .waiting      (waiting),
        .idle         (idle),
        .up_cmd       (ugate_cmd),
        .dn_cmd       (lgate_cmd),
        .trip         (fault)
    );

endmodule

// File: rtl/gno_checker.sv
module gno_checker (
    input logic clk,
    input logic rst_n,
    input logic pwm_in,
    input logic enable,
    input logic upper_gate_low,
    input logic lower_gate_low,
    input logic ugate_cmd,
    input logic lgate_cmd,
    input logic fault
);

    a_r2_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(ugate_cmd && lgate_cmd));

    a_r3_upper_after_lower_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ugate_cmd) |-> ($past(lower_gate_low) && !$past(lgate_cmd)));

    a_r4_lower_after_upper_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lgate_cmd) |-> ($past(upper_gate_low) && !$past(ugate_cmd)));

    a_r5_upper_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ugate_cmd && !pwm_in) |=> !ugate_cmd);

    a_r5_lower_release: assert property (@(posedge clk) disable iff (!rst_n)
        (lgate_cmd && pwm_in) |=> !lgate_cmd);

    a_r6_pulse_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (ugate_cmd && pwm_in) |=> ugate_cmd);

    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !ugate_cmd && !lgate_cmd) |=> (!ugate_cmd && !lgate_cmd));

    a_r8_low_side_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (lgate_cmd && !pwm_in && enable) |=> lgate_cmd);

    a_r9_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!ugate_cmd && !lgate_cmd));

    a_r9_fault_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> (!$past(ugate_cmd) && !$past(lgate_cmd)));

    a_r9_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && enable) |=> fault);

endmodule

bind gate_nonoverlap_ctrl gno_checker u_chk (.*);

// File: tb/gate_nonoverlap_ctrl_test.sv
module gate_nonoverlap_ctrl_test;

    localparam int LIM = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_in = 1'b0;
    logic enable = 1'b0;
    logic upper_gate_low = 1'b0;
    logic lower_gate_low = 1'b0;
    logic ugate_cmd, lgate_cmd, fault;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gate_nonoverlap_ctrl #(.WAIT_LIMIT(LIM)) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .pwm_in         (pwm_in),
        .enable         (enable),
        .upper_gate_low (upper_gate_low),
        .lower_gate_low (lower_gate_low),
        .ugate_cmd      (ugate_cmd),
        .lgate_cmd      (lgate_cmd),
        .fault          (fault)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Pack outputs as {u,l,f} for compact comparison.
    function automatic int outs();
        return {29'd0, ugate_cmd, lgate_cmd, fault};
    endfunction

    task automatic expect_outs(input string req, input bit u, input bit l, input bit f);
        int e;
        e = {29'd0, u, l, f};
        chk(outs() == e, req, outs(), e);
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int hcnt, lcnt, dly, run, hold;
        bit pu, pl, plo, phi;
        void'($urandom(32'd5077));
        @(negedge clk);
        step(3);
        rst_n = 1'b1;
        expect_outs("R1 reset state", 0, 0, 0);
        step(2);
        expect_outs("R1 idle after reset", 0, 0, 0);

        // Start with high request; low gate already off.
        enable = 1'b1; pwm_in = 1'b1; lower_gate_low = 1'b1; upper_gate_low = 1'b1;
        step(1);
        expect_outs("R3 dead cycle before high side", 0, 0, 0);
        step(1);
        expect_outs("R3 high side on", 1, 0, 0);

        // Request low; upper gate not yet discharged.
        pwm_in = 1'b0; upper_gate_low = 1'b0;
        step(1);
        expect_outs("R5 high side released", 0, 0, 0);
        step(4);
        expect_outs("R4 low side withheld", 0, 0, 0);
        upper_gate_low = 1'b1;
        step(1);
        expect_outs("R4 low side after upper off", 0, 1, 0);
        step(30);
        expect_outs("R8 zero duty holds low side", 0, 1, 0);

        pwm_in = 1'b1;
        step(1);
        expect_outs("R5 low side released", 0, 0, 0);
        step(1);
        expect_outs("R3 high side again", 1, 0, 0);
        step(30);
        expect_outs("R8 full duty holds high side", 1, 0, 0);

        // Disable in mid pulse.
        enable = 1'b0;
        step(5);
        expect_outs("R6 pulse continues after disable", 1, 0, 0);
        pwm_in = 1'b0;
        step(1);
        expect_outs("R6 stop at pulse end", 0, 0, 0);
        for (int i = 0; i < 6; i++) begin
            pwm_in = i[0];
            step(1);
            expect_outs("R7 quiet while disabled", 0, 0, 0);
        end

        // Disable during low-side conduction.
        enable = 1'b1; pwm_in = 1'b0; upper_gate_low = 1'b1;
        step(2);
        expect_outs("R4 low side after restart", 0, 1, 0);
        enable = 1'b0;
        step(1);
        expect_outs("R7 immediate stop in low phase", 0, 0, 0);
        pwm_in = 1'b1;
        step(3);
        expect_outs("R7 pwm ignored while disabled", 0, 0, 0);

        // Timeout: lower gate never reports off.
        enable = 1'b1; pwm_in = 1'b1; lower_gate_low = 1'b0;
        step(LIM);
        expect_outs("R9 no fault before limit", 0, 0, 0);
        step(1);
        expect_outs("R9 fault at limit", 0, 0, 1);
        lower_gate_low = 1'b1;
        step(3);
        expect_outs("R9 fault sticky while enabled", 0, 0, 1);
        enable = 1'b0;
        step(1);
        expect_outs("R9 fault cleared by disable", 0, 0, 0);

        // Random phase with a gate discharge model.
        hcnt = 15; lcnt = 15; dly = 2; run = 0; hold = 0;
        upper_gate_low = 1'b1; lower_gate_low = 1'b1; enable = 1'b1;
        for (int c = 0; c < 4000; c++) begin
            if ((c % 250) == 0) dly = $urandom_range(1, 4);
            if (run == 0) begin
                pwm_in = 1'($urandom_range(0, 1));
                run = $urandom_range(1, 12);
                if ($urandom_range(0, 40) == 0) run = 60;
            end
            run--;
            if (hold > 0) begin
                hold--;
                enable = (hold == 0);
            end else if ($urandom_range(0, 99) == 0) begin
                hold = $urandom_range(1, 6);
                enable = 1'b0;
            end
            pu = ugate_cmd; pl = lgate_cmd; plo = lower_gate_low; phi = upper_gate_low;
            step(1);
            chk(!(ugate_cmd && lgate_cmd), "R2 never both", outs(), 0);
            if (ugate_cmd && !pu)
                chk(!pl && plo, "R3 high on needs low off", {30'd0, pl, plo}, 1);
            if (lgate_cmd && !pl)
                chk(!pu && phi, "R4 low on needs high off", {30'd0, pu, phi}, 1);
            chk(!fault, "R9 no fault with timely sense", fault, 0);
            hcnt = ugate_cmd ? 0 : ((hcnt < 15) ? hcnt + 1 : hcnt);
            lcnt = lgate_cmd ? 0 : ((lcnt < 15) ? lcnt + 1 : lcnt);
            upper_gate_low = !ugate_cmd && (hcnt >= dly);
            lower_gate_low = !lgate_cmd && (lcnt >= dly);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule